// File: doc/BRIEF.md
# Dual-Layer Pixel Serializer with RGBI Palette Mixer

The block turns two parallel video words, one for a foreground bitmap layer and one for a background tile layer, into a stream of colour pixels. Each 24-bit word packs six horizontal 4-bit pixels. A load strobe arrives once per word period, and the block then emits one pixel every `PIX_DIV` clocks, most significant nibble first. Each layer carries its own 6-bit colour bank, which is sampled on the load strobe. The bank is joined to the pixel nibble to give a 10-bit palette index.

A foreground pixel with a nonzero value takes priority; a zero foreground pixel lets the background pixel through. The chosen index reads a 1024 x 16 palette. Each palette entry is `[15:12]` red, `[11:8]` green, `[7:4]` blue and `[3:0]` intensity. The block scales each colour channel by the intensity and registers the result. A blanking input forces all four outputs to zero. A host loads the palette one byte lane at a time through a simple write port.

Top module: `rgbi_pixel_mixer`

## Requirements
- R1: While `rst_ni` is low, all four colour outputs are zero.
- R2: After a cycle with `word_load_i` high, the layer words are emitted as six 4-bit pixels, bits [23:20] first and bits [3:0] last. Each pixel is held for `PIX_DIV` (default 2) clocks.
- R3: If the foreground pixel is nonzero, the palette index uses the foreground; otherwise it uses the background pixel.
- R4: The palette index is `{bank, pixel}` with the bank in bits [9:4]. Each layer's bank is captured on `word_load_i`, and later changes of the bank inputs have no effect on the current word.
- R5: With `pal_we_i` high, `pal_hi_i`=1 writes `pal_wdata_i` to entry bits [15:8] and `pal_hi_i`=0 writes entry bits [7:0]. The other byte of the entry is kept.
- R6: The red, green and blue outputs equal floor(channel x intensity / 15) of the selected entry. `inten_o` is the entry's intensity field.
- R7: When `blank_i` is high in the cycle a pixel's index is first presented, that pixel's outputs are all zero.
- R8: A pixel's output appears two clocks after its index is first presented: one clock for the palette read and one for scaling.
- R9: If a word has been fully shifted and no new load has arrived, both layers present pixel value 0.
- R10: A load strobe in the middle of a word restarts serialization at the new word's bits [23:20] and resets the pixel timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_load_i | input | 1 | Loads both layer words and banks |
| fg_word_i | input | 24 | Foreground word, six pixels |
| bg_word_i | input | 24 | Background word, six pixels |
| fg_bank_i | input | 6 | Foreground colour bank |
| bg_bank_i | input | 6 | Background colour bank |
| blank_i | input | 1 | Blanking, aligned to index presentation |
| pal_we_i | input | 1 | Palette byte write enable |
| pal_hi_i | input | 1 | 1: write bits [15:8], 0: bits [7:0] |
| pal_addr_i | input | 10 | Palette entry address |
| pal_wdata_i | input | 8 | Palette byte data |
| red_o | output | 4 | Scaled red |
| green_o | output | 4 | Scaled green |
| blue_o | output | 4 | Scaled blue |
| inten_o | output | 4 | Intensity field |

## Verification
Some properties are checked by assertions on every cycle:
- A load presents the top nibble on the next cycle.
- Pixels stay stable between shift points.
- A drained shifter presents zero.
- Blanking clears the outputs.
- Scaling never makes a channel larger than its unscaled value.

Other behaviour only the bench scenarios can show. The scenarios check the layer priority, bank capture at load time, byte-lane palette writes, the exact output value of every pixel at its two-cycle latency, blanking of individual pixels, mid-word reloads and over-long words.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
  localparam int unsigned PIX_W        = 4;
  localparam int unsigned PIX_PER_WORD = 6;
  localparam int unsigned BANK_W       = 6;
  localparam int unsigned CH_W         = 4;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
    logic [CH_W-1:0] inten;
  } rgbi_t;
endpackage

// File: rtl/pxm_serializer.sv
module pxm_serializer #(
  parameter int unsigned PIX_W = 4,
  parameter int unsigned NPIX  = 6,
  parameter int unsigned DIV   = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [PIX_W*NPIX-1:0]   word_i,
  output logic [PIX_W-1:0]        pix_o
);
  localparam int unsigned WORD_W = PIX_W * NPIX;
  localparam int unsigned PH_W   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned CNT_W  = $clog2(NPIX + 1);

  logic [WORD_W-1:0] sh_q;
  logic [PH_W-1:0]   ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              step;

  assign step  = (ph_q == PH_W'(DIV - 1));
  assign pix_o = sh_q[WORD_W-1 -: PIX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      ph_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      ph_q  <= '0;
      cnt_q <= '0;
    end else if (step) begin
      ph_q <= '0;
      sh_q <= {sh_q[WORD_W-PIX_W-1:0], {PIX_W{1'b0}}};
      if (cnt_q != CNT_W'(NPIX)) cnt_q <= cnt_q + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // R2: top nibble first after a load
  a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pix_o == $past(word_i[WORD_W-1 -: PIX_W]));

  // R2: pixel held between shift points
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step) |=> $stable(pix_o));

  // R9: drained shifter yields zero pixels
  a_r9_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(NPIX)) |-> (pix_o == '0));
endmodule

// File: rtl/pxm_palette.sv
module pxm_palette #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ENT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               hi_i,
  input  logic [IDX_W-1:0]   waddr_i,
  input  logic [ENT_W/2-1:0] wdata_i,
  input  logic [IDX_W-1:0]   raddr_i,
  output logic [ENT_W-1:0]   rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned HALF  = ENT_W / 2;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      if (hi_i) mem[waddr_i][ENT_W-1:HALF] <= wdata_i;
      else      mem[waddr_i][HALF-1:0]     <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/pxm_rgbi_scale.sv
module pxm_rgbi_scale
  import pxm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rgbi_t ent_i,
  input  logic  blank_i,
  output rgbi_t pix_o
);
  localparam int unsigned NCH  = 3;
  localparam int unsigned PR_W = 2 * CH_W;
  localparam logic [PR_W-1:0] FULL = PR_W'((1 << CH_W) - 1);

  logic [CH_W-1:0] col_in  [NCH];
  logic [CH_W-1:0] col_out [NCH];
  logic [CH_W-1:0] col_q   [NCH];
  logic [CH_W-1:0] int_q;

  assign col_in[0] = ent_i.red;
  assign col_in[1] = ent_i.green;
  assign col_in[2] = ent_i.blue;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PR_W-1:0] prod;
    assign prod       = {{CH_W{1'b0}}, col_in[c]} * {{CH_W{1'b0}}, ent_i.inten};
    assign col_out[c] = CH_W'(prod / FULL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      col_q[c] <= '0;
      else if (blank_i) col_q[c] <= '0;
      else              col_q[c] <= col_out[c];
    end

    // R6: scaling never raises a channel
    a_r6_no_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> col_q[c] <= $past(col_in[c]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      int_q <= '0;
    else if (blank_i) int_q <= '0;
    else              int_q <= ent_i.inten;
  end

  assign pix_o = '{red: col_q[0], green: col_q[1], blue: col_q[2], inten: int_q};

  // R7: blanked pixel gives black output
  a_r7_blank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (pix_o == '0));
endmodule

// File: rtl/rgbi_pixel_mixer.sv
module rgbi_pixel_mixer
  import pxm_pkg::*;
#(
  parameter int unsigned PIX_DIV = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           word_load_i,
  input  logic [PIX_W*PIX_PER_WORD-1:0]  fg_word_i,
  input  logic [PIX_W*PIX_PER_WORD-1:0]  bg_word_i,
  input  logic [BANK_W-1:0]              fg_bank_i,
  input  logic [BANK_W-1:0]              bg_bank_i,
  input  logic                           blank_i,
  input  logic                           pal_we_i,
  input  logic                           pal_hi_i,
  input  logic [BANK_W+PIX_W-1:0]        pal_addr_i,
  input  logic [7:0]                     pal_wdata_i,
  output logic [CH_W-1:0]                red_o,
  output logic [CH_W-1:0]                green_o,
  output logic [CH_W-1:0]                blue_o,
  output logic [CH_W-1:0]                inten_o
);
  localparam int unsigned IDX_W = BANK_W + PIX_W;
  localparam int unsigned ENT_W = 4 * CH_W;
  localparam int unsigned NLAY  = 2;

  logic [PIX_W*PIX_PER_WORD-1:0] word_in [NLAY];
  logic [BANK_W-1:0]             bank_in [NLAY];
  logic [BANK_W-1:0]             bank_q  [NLAY];
  logic [PIX_W-1:0]              pix     [NLAY];
  logic [IDX_W-1:0]              idx;
  logic [ENT_W-1:0]              ent;
  logic                          blank_q;
  rgbi_t                         out;

  assign word_in[0] = fg_word_i;
  assign word_in[1] = bg_word_i;
  assign bank_in[0] = fg_bank_i;
  assign bank_in[1] = bg_bank_i;

  for (genvar l = 0; l < NLAY; l++) begin : g_layer
    pxm_serializer #(.PIX_W(PIX_W), .NPIX(PIX_PER_WORD), .DIV(PIX_DIV)) u_ser (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (word_load_i),
      .word_i (word_in[l]),
      .pix_o  (pix[l])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          bank_q[l] <= '0;
      else if (word_load_i) bank_q[l] <= bank_in[l];
    end
  end

  // foreground wins on any nonzero value
  assign idx = (pix[0] != '0) ? {bank_q[0], pix[0]} : {bank_q[1], pix[1]};

  pxm_palette #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_pal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we_i),
    .hi_i    (pal_hi_i),
    .waddr_i (pal_addr_i),
    .wdata_i (pal_wdata_i),
    .raddr_i (idx),
    .rdata_o (ent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blank_q <= 1'b1;
    else         blank_q <= blank_i;
  end

  pxm_rgbi_scale u_scale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ent_i   (rgbi_t'(ent)),
    .blank_i (blank_q),
    .pix_o   (out)
  );

  assign red_o   = out.red;
  assign green_o = out.green;
  assign blue_o  = out.blue;
  assign inten_o = out.inten;

  // R4: bank held for the whole word
  a_r4_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_load_i |=> $stable(bank_q[0]) && $stable(bank_q[1]));
endmodule

// File: tb/rgbi_pixel_mixer_tb.sv
module rgbi_pixel_mixer_tb;
  localparam time TCK = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [23:0] fg_w = '0, bg_w = '0;
  logic [5:0]  fg_b = '0, bg_b = '0;
  logic        blank = 1'b1;
  logic        we = 1'b0, hi = 1'b0;
  logic [9:0]  waddr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  r, g, b, i;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] model [1024];

  typedef struct {
    int          cyc;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb[$];
  item_t it;

  always #(TCK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rgbi_pixel_mixer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .word_load_i(load),
    .fg_word_i(fg_w), .bg_word_i(bg_w), .fg_bank_i(fg_b), .bg_bank_i(bg_b),
    .blank_i(blank), .pal_we_i(we), .pal_hi_i(hi), .pal_addr_i(waddr),
    .pal_wdata_i(wdata), .red_o(r), .green_o(g), .blue_o(b), .inten_o(i)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [3:0] nib(input logic [23:0] w, input int k);
    return (k < 6) ? w[23-4*k -: 4] : 4'h0;
  endfunction

  // R3 R4 R6 R7 model
  function automatic logic [15:0] expect_px(input logic [3:0] fp, input logic [3:0] bp,
                                            input logic [5:0] fb, input logic [5:0] bb,
                                            input logic bl);
    logic [9:0]  ix;
    logic [15:0] e;
    int in;
    ix = (fp != 0) ? {fb, fp} : {bb, bp};
    e  = model[ix];
    if (bl) return 16'h0;
    in = int'(e[3:0]);
    return {4'(int'(e[15:12]) * in / 15), 4'(int'(e[11:8]) * in / 15),
            4'(int'(e[7:4]) * in / 15), e[3:0]};
  endfunction

  task automatic pal_write(input logic [9:0] a, input logic h, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; hi = h; waddr = a; wdata = d;
    if (h) model[a][15:8] = d;
    else   model[a][7:0]  = d;
  endtask

  task automatic run_line(input logic [23:0] fw, input logic [23:0] bw,
                          input logic [5:0] fb, input logic [5:0] bb,
                          input logic [7:0] bl, input int npix, input string tag);
    int n;
    item_t x;
    @(negedge clk);
    we = 1'b0;
    n = cyc;
    load = 1'b1; fg_w = fw; bg_w = bw; fg_b = fb; bg_b = bb;
    for (int k = 0; k < npix; k++) begin
      x.cyc = n + 2*k + 3;
      x.exp = expect_px(nib(fw, k), nib(bw, k), fb, bb, bl[k]);
      x.req = tag;
      sb.push_back(x);
    end
    for (int j = 1; j < 2*npix; j++) begin
      @(negedge clk);
      load = 1'b0;
      fg_b = fb ^ 6'h2A; bg_b = bb ^ 6'h15;   // R4: late bank changes ignored
      fg_w = ~fw; bg_w = ~bw;
      blank = bl[(j-1)/2];
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0 && sb[0].cyc <= cyc) begin
      it = sb.pop_front();
      if (it.cyc < cyc) begin
        checks++; fails++;
        $display("FAIL %s actual=missed expected=cycle %0d", it.req, it.cyc);
      end else begin
        check(it.req, {r, g, b, i}, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs zero in reset
    repeat (3) begin
      @(negedge clk);
      check("R1", {r, g, b, i}, 16'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 1024; a++) begin
      logic [15:0] v;
      v = 16'(a * 40503) ^ 16'h5A3C;
      pal_write(10'(a), 1'b1, v[15:8]);
      pal_write(10'(a), 1'b0, v[7:0]);
    end

    // R2 R3 R6 R8: all-foreground line
    run_line(24'h123456, 24'h789ABC, 6'd5, 6'd9, 8'h00, 6, "R2/R6/R8");
    // R3: zero foreground nibbles fall back
    run_line(24'h0F00A0, 24'h13579B, 6'd33, 6'd12, 8'h00, 6, "R3");
    // R7: per-pixel blanking
    run_line(24'h000000, 24'hFEDCBA, 6'd1, 6'd62, 8'b0010_1001, 6, "R7");
    // R5: high byte write keeps low byte
    pal_write({6'd40, 4'h7}, 1'b1, 8'hF3);
    pal_write({6'd41, 4'h2}, 1'b0, 8'hCF);
    run_line(24'h000200, 24'h777777, 6'd41, 6'd40, 8'h00, 6, "R5");
    // R10: reload after three pixels
    run_line(24'h9ABCDE, 24'h111111, 6'd7, 6'd8, 8'h00, 3, "R10");
    run_line(24'hABC000, 24'h24680F, 6'd20, 6'd21, 8'h00, 6, "R10");
    // R9: no reload past six pixels
    run_line(24'h111111, 24'h222222, 6'd3, 6'd50, 8'h00, 8, "R9");
    // R4 R6: assorted words and banks
    for (int t = 0; t < 20; t++) begin
      logic [23:0] fw, bw;
      fw = 24'(t * 699053) & ((t % 3 == 0) ? 24'hF0F0F0 : 24'hFFFFFF);
      bw = 24'(t * 1398101 + 3);
      run_line(fw, bw, 6'(t * 7), 6'(t * 11 + 1), 8'(t * 37) & 8'h21, 6, "R4/R6");
    end

    while (sb.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule